// File: doc/BRIEF.md
# Port Input Interrupt Unit

This block conditions a small general-purpose input port and turns its pin activity into interrupt requests, CPU branch conditions and counter event clocks. Every pin is first brought into the system clock domain through a two-flop synchroniser. It then passes through a per-bit filter that accepts a new level only after that level has held across two rising edges of a slow filter clock. For each bit, software chooses whether the interrupt and event paths use the filtered level or the synchronised pin directly. Software also chooses whether the level is inverted before edge detection. The effect is to pick a rising or a falling active edge.

A request is stored in a per-bit flag only when that bit's enable (mask) is 1. A software write of 1 clears a flag. A set and a clear in the same cycle leave the flag set. The CPU branch conditions always come from the filtered levels of bits 0 and 1, whatever the bypass setting. Bits 0 and 3 leave the block as counter event inputs after the same source selection and inversion as the interrupts. Edge detection follows the inversion stage, so changing the edge choice while a pin is steady can itself raise a request.

Top module: `port_irq_unit`

## Requirements
- R1: After reset the enable, flag, edge-select and bypass registers are all 0, and irq_o is 0.
- R2: A filtered level follows its pin only after the pin has been stable across two rising edges of deb_clk_i. A pulse shorter than one deb_clk_i period never reaches the filtered level.
- R3: Bypass bit n = 1 makes bit n's interrupt and event paths use the synchronised pin directly, with no filtering. Bypass bit n = 0 selects the filtered level.
- R4: Edge-select bit n = 0 makes a rising edge of the selected level the active edge. Edge-select bit n = 1 inverts the level, which makes a falling edge active.
- R5: A change of edge-select bit n that causes the inverted level to go from 0 to 1 raises a request on bit n when that bit is enabled, even though the pin itself stays steady.
- R6: While enable bit n is 0, no request is stored on bit n. After the enable is set to 1, the flag is set only by the next active edge.
- R7: Writing 1 to a flag bit (reg_sel_i = 1) clears that bit. Writing 0 leaves it unchanged.
- R8: If a flag is set and cleared by a write in the same cycle, the flag ends up set.
- R9: test_var_o[0] and test_var_o[1] are the filtered levels of pins 0 and 1, whatever the bypass bits hold.
- R10: event_o[0] and event_o[1] carry pins 0 and 3 after the same bypass selection and edge-select inversion that the interrupt path uses.
- R11: Register select codes: 0 is enable, 1 is flags, 2 is edge-select and 3 is bypass. Bit n of each register belongs to pin n. reg_rdata_o returns the register chosen by reg_sel_i, combinationally.
- R12: irq_o bit n is high exactly while flag bit n is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4 | Raw port pins |
| deb_clk_i | input | 1 | Slow filter clock, sampled in the clk_i domain |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 enable, 1 flags, 2 edge, 3 bypass) |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Read data of the selected register |
| irq_o | output | 4 | Per-bit interrupt request lines |
| test_var_o | output | 2 | Filtered pins 0 and 1 for CPU branch tests |
| event_o | output | 2 | Event inputs for the counter, from pins 0 and 3 |

## Verification
The bench drives pulses shorter than one filter period. A filter that reacts to a single filter-clock edge, or does not restart its count when the pin moves, would let such a pulse through to the branch conditions or the flags. It switches the edge choice while a pin is held low and expects a request. A design that detected edges on the raw pin would stay silent there. It toggles pins while the enable is 0 and then enables the bit. A design that only masked the output would raise irq_o at once. It also lines up a pin edge with a clear write in the same cycle, which catches a design that lets the clear win and loses the event.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
  localparam int unsigned PORT_W = 4;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_EDGE = 2'd2,
    SEL_BYP  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/deb_filter.sv
module deb_filter #(
  parameter int unsigned N_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic tick_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2(N_EDGES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(N_EDGES);
  localparam logic [CW-1:0] CNT_LST = CW'(N_EDGES - 1);

  logic          d_q;
  logic [CW-1:0] cnt_q;
  logic          q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q   <= 1'b0;
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else begin
      d_q <= d_i;
      if (d_i != d_q) begin
        cnt_q <= '0;
      end else if (tick_i && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_LST) q_q <= d_i;
      end
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/irq_bit.sv
module irq_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic direct_i,
  input  logic filt_i,
  input  logic byp_i,
  input  logic inv_i,
  input  logic en_i,
  input  logic clr_i,
  output logic pol_o,
  output logic set_o,
  output logic flag_o
);
  logic pol_q, flag_q;

  assign pol_o = (byp_i ? direct_i : filt_i) ^ inv_i;
  assign set_o = en_i & pol_o & ~pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pol_q <= pol_o;
      if (set_o)      flag_q <= 1'b1;  // set beats clear
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/port_irq_unit.sv
module port_irq_unit
  import port_irq_pkg::*;
#(
  parameter int unsigned W       = PORT_W,
  parameter int unsigned N_EDGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic         deb_clk_i,
  input  logic         reg_we_i,
  input  logic [1:0]   reg_sel_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic [W-1:0] irq_o,
  output logic [1:0]   test_var_o,
  output logic [1:0]   event_o
);
  localparam int unsigned EV_HI = W - 1;

  reg_sel_e     sel;
  logic [W-1:0] sync_v, filt_v, pol_v, set_v, flag_q;
  logic [W-1:0] mask_q, edge_q, byp_q;
  logic         deb_q, deb_tick;
  logic         wr_mask, wr_flag, wr_edge, wr_byp;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign wr_mask = reg_we_i && sel == SEL_MASK;
  assign wr_flag = reg_we_i && sel == SEL_FLAG;
  assign wr_edge = reg_we_i && sel == SEL_EDGE;
  assign wr_byp  = reg_we_i && sel == SEL_BYP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      edge_q <= '0;
      byp_q  <= '0;
      deb_q  <= 1'b0;
    end else begin
      deb_q <= deb_clk_i;
      if (wr_mask) mask_q <= reg_wdata_i;
      if (wr_edge) edge_q <= reg_wdata_i;
      if (wr_byp)  byp_q  <= reg_wdata_i;
    end
  end

  assign deb_tick = deb_clk_i & ~deb_q;

  pin_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_v)
  );

  for (genvar n = 0; n < W; n++) begin : g_bit
    deb_filter #(.N_EDGES(N_EDGES)) u_deb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (sync_v[n]),
      .tick_i(deb_tick),
      .q_o   (filt_v[n])
    );
    irq_bit u_irq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .direct_i(sync_v[n]),
      .filt_i  (filt_v[n]),
      .byp_i   (byp_q[n]),
      .inv_i   (edge_q[n]),
      .en_i    (mask_q[n]),
      .clr_i   (wr_flag & reg_wdata_i[n]),
      .pol_o   (pol_v[n]),
      .set_o   (set_v[n]),
      .flag_o  (flag_q[n])
    );
  end

  always_comb begin
    unique case (sel)
      SEL_MASK: reg_rdata_o = mask_q;
      SEL_FLAG: reg_rdata_o = flag_q;
      SEL_EDGE: reg_rdata_o = edge_q;
      default:  reg_rdata_o = byp_q;
    endcase
  end

  assign irq_o      = flag_q;
  assign test_var_o = filt_v[1:0];
  assign event_o    = {pol_v[EV_HI], pol_v[0]};
endmodule

// File: rtl/port_irq_unit_chk.sv
module port_irq_unit_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         reg_we_i,
  input logic [1:0]   reg_sel_i,
  input logic [W-1:0] reg_wdata_i,
  input logic [W-1:0] reg_rdata_o,
  input logic [W-1:0] irq_o,
  input logic [1:0]   test_var_o,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] set_v,
  input logic         deb_tick
);
  p_mask_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~$past(irq_o) & ~$past(mask_q)) == '0);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 2'd1) |=> ((irq_o & $past(reg_wdata_i) & ~$past(set_v)) == '0));

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_v) |=> ((irq_o & $past(set_v)) == $past(set_v)));

  p_filter_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(test_var_o) |-> $past(deb_tick));

  p_rdata_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 2'd1) |-> (reg_rdata_o == irq_o));
endmodule

bind port_irq_unit port_irq_unit_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_sel_i  (reg_sel_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .test_var_o (test_var_o),
  .mask_q     (mask_q),
  .set_v      (set_v),
  .deb_tick   (deb_tick)
);

// File: tb/port_irq_unit_bench.sv
module port_irq_unit_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] pin_i = '0;
  logic       deb_clk_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_sel_i = '0;
  logic [3:0] reg_wdata_i = '0;
  logic [3:0] reg_rdata_o, irq_o;
  logic [1:0] test_var_o, event_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;    // 50 MHz
  always #160 deb_clk_i = ~deb_clk_i;  // 16 system clocks per filter period

  port_irq_unit u_port_irq_unit (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] s, input logic [3:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = s; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [3:0] d);
    @(negedge clk_i);
    reg_sel_i = s;
    #1 d = reg_rdata_o;
  endtask

  task automatic clear_all;
    wr(2'd1, 4'hF);
  endtask

  task automatic t_reset;
    logic [3:0] d;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), d);
      chk(d == 4'h0, "R1 register after reset", d, 0);
    end
    chk(irq_o == 4'h0, "R1 irq after reset", irq_o, 0);
  endtask

  task automatic t_regmap;
    logic [3:0] d;
    wr(2'd3, 4'h5); rd(2'd3, d);
    chk(d == 4'h5, "R11 bypass readback", d, 5);
    wr(2'd2, 4'hA); rd(2'd2, d);
    chk(d == 4'hA, "R11 edge readback", d, 'hA);
    wr(2'd2, 4'h0); wr(2'd3, 4'h0);
  endtask

  task automatic t_debounce;
    wr(2'd0, 4'h1);
    pin_i[0] = 1'b1;
    cyc(4);
    pin_i[0] = 1'b0;
    cyc(50);
    chk(test_var_o[0] == 1'b0, "R2 short pulse rejected", test_var_o[0], 0);
    chk(irq_o[0] == 1'b0, "R2 short pulse no request", irq_o[0], 0);
    pin_i[0] = 1'b1;
    cyc(10);
    chk(test_var_o[0] == 1'b0, "R2 no update before second filter edge", test_var_o[0], 0);
    cyc(40);
    chk(test_var_o[0] == 1'b1, "R2 filtered level follows", test_var_o[0], 1);
    chk(irq_o[0] == 1'b1, "R4 rising edge request", irq_o[0], 1);
    chk(event_o[0] == 1'b1, "R10 event 0 filtered", event_o[0], 1);
    pin_i[0] = 1'b0;
    cyc(50);
    clear_all();
    wr(2'd0, 4'h0);
  endtask

  task automatic t_bypass;
    wr(2'd3, 4'h2);
    wr(2'd0, 4'h2);
    pin_i[1] = 1'b1;
    cyc(6);
    chk(irq_o[1] == 1'b1, "R3 bypass request fast", irq_o[1], 1);
    chk(test_var_o[1] == 1'b0, "R9 test var still filtered", test_var_o[1], 0);
    cyc(50);
    chk(test_var_o[1] == 1'b1, "R9 test var after filter", test_var_o[1], 1);
    pin_i[1] = 1'b0;
    cyc(50);
    chk(test_var_o[1] == 1'b0, "R9 test var returns low", test_var_o[1], 0);
    clear_all();
    wr(2'd0, 4'h0); wr(2'd3, 4'h0);
  endtask

  task automatic t_falling;
    logic [3:0] d;
    pin_i[3] = 1'b1;
    cyc(50);
    chk(event_o[1] == 1'b1, "R10 event 1 from pin 3", event_o[1], 1);
    wr(2'd2, 4'h8);
    cyc(2);
    chk(event_o[1] == 1'b0, "R10 event 1 inverted", event_o[1], 0);
    wr(2'd0, 4'h8);
    pin_i[3] = 1'b0;
    cyc(50);
    chk(irq_o[3] == 1'b1, "R4 falling edge request", irq_o[3], 1);
    rd(2'd1, d);
    chk(d == 4'h8, "R12 flag read matches irq", d, 8);
    clear_all();
    wr(2'd0, 4'h0); wr(2'd2, 4'h0);
  endtask

  task automatic t_edge_switch;
    wr(2'd0, 4'h4);
    cyc(3);
    chk(irq_o[2] == 1'b0, "R5 idle before switch", irq_o[2], 0);
    wr(2'd2, 4'h4);
    cyc(2);
    chk(irq_o[2] == 1'b1, "R5 edge switch raises request", irq_o[2], 1);
    clear_all();
    wr(2'd0, 4'h0); wr(2'd2, 4'h0);
  endtask

  task automatic t_mask;
    wr(2'd3, 4'h1);
    pin_i[0] = 1'b1; cyc(6);
    chk(irq_o[0] == 1'b0, "R6 masked edge not stored", irq_o[0], 0);
    wr(2'd0, 4'h1);
    cyc(3);
    chk(irq_o[0] == 1'b0, "R6 unmask alone sets nothing", irq_o[0], 0);
    pin_i[0] = 1'b0; cyc(6);
    chk(irq_o[0] == 1'b0, "R6 inactive edge ignored", irq_o[0], 0);
    pin_i[0] = 1'b1; cyc(6);
    chk(irq_o[0] == 1'b1, "R6 next active edge stored", irq_o[0], 1);
    wr(2'd1, 4'h0); cyc(1);
    chk(irq_o[0] == 1'b1, "R7 write 0 keeps flag", irq_o[0], 1);
    wr(2'd1, 4'h1); cyc(1);
    chk(irq_o[0] == 1'b0, "R7 write 1 clears flag", irq_o[0], 0);
    pin_i[0] = 1'b0; cyc(6);
    wr(2'd0, 4'h0); wr(2'd3, 4'h0);
    cyc(50);
  endtask

  task automatic t_set_vs_clear;
    wr(2'd3, 4'h1);
    wr(2'd0, 4'h1);
    @(negedge clk_i); pin_i[0] = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = 2'd1; reg_wdata_i = 4'h1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    chk(irq_o[0] == 1'b1, "R8 set wins over clear", irq_o[0], 1);
    clear_all();
    pin_i[0] = 1'b0;
    cyc(6);
    wr(2'd0, 4'h0); wr(2'd3, 4'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    t_reset();
    t_regmap();
    t_debounce();
    t_bypass();
    t_falling();
    t_edge_switch();
    t_mask();
    t_set_vs_clear();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule